// File: doc/BRIEF.md
# Interrupt Event Ring Producer

The block takes fixed-size interrupt event entries of 256 bits from a valid/ready input and stores each one, in arrival order, into a circular buffer held in system memory. It reaches memory through a single-word write port with a request/acknowledge handshake. The block keeps the write pointer. Software consumes entries and reports its progress by moving a read pointer. It can do this with a direct register write or with a doorbell write whose offset matches a programmed value.

While unread entries exist and both the ring and its interrupt are enabled, an interrupt line is raised. The ring keeps writing when it fills. In that case the oldest entries are overwritten, and a sticky overflow flag is set in the write-pointer register. After an overflow the consumer resumes at write pointer plus 32. Optionally, the write-pointer register image is also copied to a memory word after every entry. The block covers a single ring.

Top module: `ih_ring_producer`

## Requirements
- R1: An accepted entry is written as eight 32-bit words in ascending address order. Word i carries ev_data_i[32i+31:32i] at address ring base + write pointer + 4i. One word is written per acknowledged request, and address and data stay stable while a request waits.
- R2: After the last word of an entry is acknowledged, the write pointer advances by 32 and wraps with mask (4 << s) - 1. Here s is the size field in control bits [9:5], clamped to the range 3..MAX_LOG. The pointer occupies bits [PTR_W-1:0] of register 3.
- R3: The ring base address is {register 1 bits [7:0], register 0, 8'h00}, so the ring is 256-byte aligned.
- R4: When an entry commits, the overflow flag (register 3 bit 31) is set if three conditions hold. First, the advanced write pointer equals the read pointer held before that clock edge. Second, overflow enable (control bit 2) is 1. Third, overflow clear (control bit 3) is 0. The entry is written regardless.
- R5: While overflow clear is 1, the flag is 0 and no overflow is recorded. The flag stays set until it is cleared this way.
- R6: With write-back enabled (control bit 4), each entry is followed by one more word write. That write carries the updated register-3 image to address {register 7 bits [15:0], register 6 bits [31:2], 2'b00}.
- R7: ev_ready_o is 0 while the ring is disabled (control bit 0 = 0). It is also 0 from the cycle after an entry is accepted until its writes finish.
- R8: irq_o is 1 exactly when ring enable, interrupt enable (control bit 1) and a difference between the write and read pointers all hold.
- R9: A write to register 4 loads the read pointer with the written data ANDed with the ring mask.
- R10: A doorbell write loads the read pointer like R9. This happens only when register 5 bit 16 is 1 and db_offset_i equals register 5 bits [DB_W-1:0]; otherwise the doorbell is ignored. A register-4 write in the same cycle takes precedence.
- R11: After reset every register reads 0, irq_o is 0 and ev_ready_o is 0.
- R12: A write to register 3 loads the write pointer with the data ANDed with the mask and with 32-byte alignment, leaving the overflow flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register index for write and read |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| db_valid_i | input | 1 | Doorbell write strobe |
| db_offset_i | input | DB_W | Doorbell target offset |
| db_data_i | input | 32 | Doorbell read-pointer value |
| ev_valid_i | input | 1 | Entry valid |
| ev_ready_o | output | 1 | Entry ready |
| ev_data_i | input | 256 | Entry payload, word 0 in the low bits |
| mem_req_o | output | 1 | Memory word write request |
| mem_addr_o | output | 48 | Memory byte address |
| mem_data_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory write acknowledge |
| irq_o | output | 1 | Unread-entries interrupt |

## Verification
Two updates can land on the same clock edge: an entry's commit, which advances the write pointer and tests for overflow, and a doorbell that moves the read pointer. The bench provokes this by firing a doorbell from the memory responder in the very cycle it acknowledges the final data word. The read pointer beforehand equals the advanced write pointer. The expected result is that the overflow flag is set, because the comparison uses the old read pointer. The read pointer should also take the doorbell value, and irq_o should follow the new pair of pointers. Random entries with random consumption by register or doorbell surround this case and are checked against a pointer model in the bench.

// File: rtl/ih_pkg.sv
package ih_pkg;
  localparam int WORD_W      = 32;
  localparam int ENTRY_WORDS = 8;
  localparam int ENTRY_W     = WORD_W * ENTRY_WORDS;
  localparam int ENTRY_BYTES = ENTRY_WORDS * 4;
  localparam int ADDR_W      = 48;
  localparam int MIN_LOG     = 3;

  typedef enum logic [2:0] {
    RI_BASE_LO = 3'd0,
    RI_BASE_HI = 3'd1,
    RI_CTRL    = 3'd2,
    RI_WPTR    = 3'd3,
    RI_RPTR    = 3'd4,
    RI_DB      = 3'd5,
    RI_WB_LO   = 3'd6,
    RI_WB_HI   = 3'd7
  } reg_idx_e;

  typedef struct packed {
    logic [4:0] size;
    logic       wb_en;
    logic       ovf_clr;
    logic       ovf_en;
    logic       irq_en;
    logic       ring_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
  localparam int DB_EN_BIT = 16;
endpackage

// File: rtl/ih_size_mask.sv
module ih_size_mask import ih_pkg::*; #(
  parameter  int MAX_LOG = 12,
  localparam int PTR_W   = MAX_LOG + 2
) (
  input  logic [4:0]       size_i,
  output logic [PTR_W-1:0] mask_o
);
  localparam int SPW = PTR_W + 1;
  logic [4:0]     sz;
  logic [SPW-1:0] span;

  always_comb begin
    if (size_i < 5'(MIN_LOG))      sz = 5'(MIN_LOG);
    else if (size_i > 5'(MAX_LOG)) sz = 5'(MAX_LOG);
    else                           sz = size_i;
    span   = (SPW'(1) << (sz + 5'd2)) - SPW'(1);
    mask_o = span[PTR_W-1:0];
  end
endmodule

// File: rtl/ih_regs.sv
module ih_regs import ih_pkg::*; #(
  parameter  int MAX_LOG = 12,
  parameter  int DB_W    = 10,
  localparam int PTR_W   = MAX_LOG + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              db_valid_i,
  input  logic [DB_W-1:0]   db_offset_i,
  input  logic [31:0]       db_data_i,
  input  logic              commit_i,
  output ctrl_t             ctrl_o,
  output logic [PTR_W-1:0]  wptr_o,
  output logic [PTR_W-1:0]  rptr_o,
  output logic [ADDR_W-1:0] ring_base_o,
  output logic [ADDR_W-1:0] wb_addr_o,
  output logic [31:0]       wptr_word_o
);
  ctrl_t            ctrl_q;
  logic [31:0]      base_lo_q, wb_lo_q;
  logic [7:0]       base_hi_q;
  logic [15:0]      wb_hi_q;
  logic [PTR_W-1:0] wptr_q, rptr_q, mask, wptr_nxt;
  logic             ovf_q, db_en_q, db_hit, wr_wptr, wr_rptr;
  logic [DB_W-1:0]  db_off_q;
  logic [31:0]      db_word;

  localparam logic [PTR_W-1:0] ALIGN = ~PTR_W'(ENTRY_BYTES - 1);

  ih_size_mask #(.MAX_LOG(MAX_LOG)) u_mask (.size_i(ctrl_q.size), .mask_o(mask));

  assign wptr_nxt = (wptr_q + PTR_W'(ENTRY_BYTES)) & mask;
  assign wr_wptr  = reg_we_i && (reg_addr_i == RI_WPTR);
  assign wr_rptr  = reg_we_i && (reg_addr_i == RI_RPTR);
  assign db_hit   = db_valid_i && db_en_q && (db_offset_i == db_off_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      base_lo_q <= '0;
      base_hi_q <= '0;
      wb_lo_q   <= '0;
      wb_hi_q   <= '0;
      wptr_q    <= '0;
      rptr_q    <= '0;
      ovf_q     <= 1'b0;
      db_en_q   <= 1'b0;
      db_off_q  <= '0;
    end else begin
      if (reg_we_i) begin
        case (reg_addr_i)
          RI_BASE_LO: base_lo_q <= reg_wdata_i;
          RI_BASE_HI: base_hi_q <= reg_wdata_i[7:0];
          RI_CTRL:    ctrl_q    <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
          RI_WPTR:    wptr_q    <= reg_wdata_i[PTR_W-1:0] & mask & ALIGN;
          RI_RPTR:    rptr_q    <= reg_wdata_i[PTR_W-1:0] & mask;
          RI_DB: begin
            db_en_q  <= reg_wdata_i[DB_EN_BIT];
            db_off_q <= reg_wdata_i[DB_W-1:0];
          end
          RI_WB_LO:   wb_lo_q   <= reg_wdata_i;
          RI_WB_HI:   wb_hi_q   <= reg_wdata_i[15:0];
          default: ;
        endcase
      end
      if (commit_i && !wr_wptr) wptr_q <= wptr_nxt;
      if (db_hit && !wr_rptr)   rptr_q <= db_data_i[PTR_W-1:0] & mask;
      // overflow compares against the read pointer held before this edge
      if (ctrl_q.ovf_clr) ovf_q <= 1'b0;
      else if (commit_i && ctrl_q.ovf_en && (wptr_nxt == rptr_q)) ovf_q <= 1'b1;
    end
  end

  always_comb begin
    wptr_word_o = '0;
    wptr_word_o[31] = ovf_q;
    wptr_word_o[PTR_W-1:0] = wptr_q;
    db_word = '0;
    db_word[DB_EN_BIT] = db_en_q;
    db_word[DB_W-1:0] = db_off_q;
    case (reg_addr_i)
      RI_BASE_LO: reg_rdata_o = base_lo_q;
      RI_BASE_HI: reg_rdata_o = {24'd0, base_hi_q};
      RI_CTRL:    reg_rdata_o = 32'(ctrl_q);
      RI_WPTR:    reg_rdata_o = wptr_word_o;
      RI_RPTR:    reg_rdata_o = 32'(rptr_q);
      RI_DB:      reg_rdata_o = db_word;
      RI_WB_LO:   reg_rdata_o = {wb_lo_q[31:2], 2'b00};
      RI_WB_HI:   reg_rdata_o = {16'd0, wb_hi_q};
      default:    reg_rdata_o = '0;
    endcase
  end

  assign ctrl_o      = ctrl_q;
  assign wptr_o      = wptr_q;
  assign rptr_o      = rptr_q;
  assign ring_base_o = {base_hi_q, base_lo_q, 8'h00};
  assign wb_addr_o   = {wb_hi_q, wb_lo_q[31:2], 2'b00};

  a_r2_wptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !wr_wptr |=> wptr_q == (($past(wptr_q) + PTR_W'(ENTRY_BYTES)) & $past(mask)));
  a_r4_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q && !ctrl_q.ovf_clr |=> ovf_q);
  a_r5_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.ovf_clr |=> !ovf_q);
endmodule

// File: rtl/ih_writer.sv
module ih_writer import ih_pkg::*; #(
  parameter  int PTR_W = 14,
  localparam int CNT_W = $clog2(ENTRY_WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ring_en_i,
  input  logic               wb_en_i,
  input  logic [ADDR_W-1:0]  ring_base_i,
  input  logic [PTR_W-1:0]   wptr_i,
  input  logic [ADDR_W-1:0]  wb_addr_i,
  input  logic [31:0]        wptr_word_i,
  input  logic               ev_valid_i,
  output logic               ev_ready_o,
  input  logic [ENTRY_W-1:0] ev_data_i,
  output logic               mem_req_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic [WORD_W-1:0]  mem_data_o,
  input  logic               mem_ack_i,
  output logic               commit_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_WBACK} st_e;
  st_e              st_q;
  logic [CNT_W-1:0] idx_q;
  logic [WORD_W-1:0] buf_q [ENTRY_WORDS];
  logic             last_ack;

  assign ev_ready_o = ring_en_i && (st_q == ST_IDLE);
  assign mem_req_o  = (st_q != ST_IDLE);
  assign last_ack   = (st_q == ST_DATA) && mem_ack_i && (idx_q == CNT_W'(ENTRY_WORDS - 1));
  assign commit_o   = last_ack;

  always_comb begin
    if (st_q == ST_WBACK) begin
      mem_addr_o = wb_addr_i;
      mem_data_o = wptr_word_i;
    end else begin
      mem_addr_o = ring_base_i + ADDR_W'(wptr_i) + ADDR_W'({idx_q, 2'b00});
      mem_data_o = buf_q[idx_q];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      for (int i = 0; i < ENTRY_WORDS; i++) buf_q[i] <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (ev_valid_i && ev_ready_o) begin
          for (int i = 0; i < ENTRY_WORDS; i++) buf_q[i] <= ev_data_i[i*WORD_W +: WORD_W];
          idx_q <= '0;
          st_q  <= ST_DATA;
        end
        ST_DATA: if (mem_ack_i) begin
          if (last_ack) begin
            idx_q <= '0;
            st_q  <= wb_en_i ? ST_WBACK : ST_IDLE;
          end else begin
            idx_q <= idx_q + CNT_W'(1);
          end
        end
        ST_WBACK: if (mem_ack_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r1_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_data_o));
endmodule

// File: rtl/ih_ring_producer.sv
module ih_ring_producer import ih_pkg::*; #(
  parameter  int MAX_LOG = 12,
  parameter  int DB_W    = 10,
  localparam int PTR_W   = MAX_LOG + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              db_valid_i,
  input  logic [DB_W-1:0]   db_offset_i,
  input  logic [31:0]       db_data_i,
  input  logic              ev_valid_i,
  output logic              ev_ready_o,
  input  logic [255:0]      ev_data_i,
  output logic              mem_req_o,
  output logic [47:0]       mem_addr_o,
  output logic [31:0]       mem_data_o,
  input  logic              mem_ack_i,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [PTR_W-1:0]  wptr, rptr;
  logic [ADDR_W-1:0] ring_base, wb_addr;
  logic [31:0]       wptr_word;
  logic              commit;

  ih_regs #(.MAX_LOG(MAX_LOG), .DB_W(DB_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .db_valid_i, .db_offset_i, .db_data_i,
    .commit_i(commit), .ctrl_o(ctrl), .wptr_o(wptr), .rptr_o(rptr),
    .ring_base_o(ring_base), .wb_addr_o(wb_addr), .wptr_word_o(wptr_word)
  );

  ih_writer #(.PTR_W(PTR_W)) u_writer (
    .clk_i, .rst_ni, .ring_en_i(ctrl.ring_en), .wb_en_i(ctrl.wb_en),
    .ring_base_i(ring_base), .wptr_i(wptr), .wb_addr_i(wb_addr), .wptr_word_i(wptr_word),
    .ev_valid_i, .ev_ready_o, .ev_data_i,
    .mem_req_o, .mem_addr_o, .mem_data_o, .mem_ack_i, .commit_o(commit)
  );

  assign irq_o = ctrl.ring_en && ctrl.irq_en && (wptr != rptr);

  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_valid_i && ev_ready_o |=> !ev_ready_o && mem_req_o);
endmodule

// File: tb/tb_ih_ring_producer.sv
module tb_ih_ring_producer;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        db_v_a = 1'b0, db_v_b;
  logic [9:0]  db_off_a = '0;
  logic [31:0] db_d_a = '0, db_d_b = '0;
  logic        db_valid;
  logic [9:0]  db_offset;
  logic [31:0] db_data;
  logic        ev_valid = 1'b0, ev_ready;
  logic [255:0] ev_data = '0;
  logic        mem_req, mem_ack, irq;
  logic [47:0] mem_addr;
  logic [31:0] mem_data;

  assign db_valid  = db_v_a | db_v_b;
  assign db_offset = db_v_b ? 10'h2A : db_off_a;
  assign db_data   = db_v_b ? db_d_b : db_d_a;

  ih_ring_producer dut (
    .clk_i(clk), .rst_ni, .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .db_valid_i(db_valid), .db_offset_i(db_offset), .db_data_i(db_data),
    .ev_valid_i(ev_valid), .ev_ready_o(ev_ready), .ev_data_i(ev_data),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_data_o(mem_data), .mem_ack_i(mem_ack),
    .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [63:0] log_a [$];
  logic [31:0] log_d [$];
  bit hook_armed = 0, hook_fired = 0;
  int hook_val = 0;

  // model state
  int exp_wptr = 0, exp_rptr = 0, mask = 31;
  bit exp_ovf = 0;
  bit ring_en = 0, irq_en = 0, ovf_en = 0, clr = 0, wb_en = 0;
  int size = 0;
  localparam logic [63:0] BASE = {16'd0, 8'h3C, 32'h00AB_CD12, 8'h00};
  localparam logic [63:0] WBA  = {16'd0, 16'h0012, 32'h0000_F004};

  function automatic int f_mask(int s);
    int c = (s < 3) ? 3 : ((s > 12) ? 12 : s);
    return (4 << c) - 1;
  endfunction
  function automatic logic [31:0] f_img(int w, bit o);
    return {o, 31'(w)};
  endfunction
  function automatic bit f_irq();
    return ring_en && irq_en && (exp_wptr != exp_rptr);
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask
  task automatic reg_rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask
  task automatic set_ctrl();
    reg_wr(3'd2, {22'd0, 5'(size), wb_en, clr, ovf_en, irq_en, ring_en});
    mask = f_mask(size);
    if (clr) exp_ovf = 0;
  endtask
  task automatic set_rptr_reg(int v);
    logic [31:0] d;
    reg_wr(3'd4, 32'(v)); exp_rptr = v;
    reg_rd(3'd4, d);
    chk("R9 rptr reg write", 64'(d), 64'(v));
    chk("R8 irq after rptr", 64'(irq), 64'(f_irq()));
  endtask
  task automatic set_rptr_db(int v);
    logic [31:0] d;
    @(negedge clk); db_v_a = 1'b1; db_off_a = 10'h2A; db_d_a = 32'(v);
    @(negedge clk); db_v_a = 1'b0; exp_rptr = v;
    reg_rd(3'd4, d);
    chk("R10 doorbell rptr", 64'(d), 64'(v));
    chk("R8 irq after doorbell", 64'(irq), 64'(f_irq()));
  endtask

  task automatic send_entry(logic [255:0] data);
    int nw = wb_en ? 9 : 8;
    int nxt;
    bit hit;
    logic [31:0] d;
    log_a.delete(); log_d.delete();
    @(negedge clk); ev_data = data; ev_valid = 1'b1;
    while (!ev_ready) @(negedge clk);
    @(negedge clk); ev_valid = 1'b0;
    chk("R7 ready low while busy", 64'(ev_ready), 64'd0);
    while (log_a.size() < nw) @(negedge clk);
    repeat (2) @(negedge clk);
    nxt = (exp_wptr + 32) & mask;
    hit = ovf_en && !clr && (nxt == exp_rptr);
    for (int i = 0; i < 8; i++) begin
      chk("R1/R3 word addr", log_a[i], BASE + 64'(exp_wptr) + 64'(4 * i));
      chk("R1 word data", 64'(log_d[i]), 64'(data[i*32 +: 32]));
    end
    exp_wptr = nxt;
    if (hit) exp_ovf = 1;
    if (clr) exp_ovf = 0;
    if (hook_armed) begin exp_rptr = hook_val; hook_armed = 0; hook_fired = 0; end
    if (wb_en) begin
      chk("R6 writeback addr", log_a[8], WBA);
      chk("R6 writeback data", 64'(log_d[8]), 64'(f_img(exp_wptr, exp_ovf)));
    end
    chk("R1 write count", 64'(log_a.size()), 64'(nw));
    reg_rd(3'd3, d);
    chk("R2/R4 wptr register", 64'(d), 64'(f_img(exp_wptr, exp_ovf)));
    chk("R8 irq after entry", 64'(irq), 64'(f_irq()));
  endtask

  function automatic logic [255:0] rnd_entry();
    logic [255:0] e;
    for (int i = 0; i < 8; i++) e[i*32 +: 32] = $urandom;
    return e;
  endfunction

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  // memory responder; also fires the same-edge doorbell hook
  initial begin
    mem_ack = 1'b0; db_v_b = 1'b0;
    forever begin
      @(negedge clk);
      db_v_b = 1'b0; mem_ack = 1'b0;
      if (rst_ni && mem_req && ($urandom % 4) != 0) begin
        mem_ack = 1'b1;
        log_a.push_back(64'(mem_addr));
        log_d.push_back(mem_data);
        if (hook_armed && !hook_fired && log_a.size() == 8) begin
          db_v_b = 1'b1; db_d_b = 32'(hook_val); hook_fired = 1;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1D5));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R11 reset state
    for (int a = 0; a < 8; a++) begin
      reg_rd(3'(a), d);
      chk("R11 reset register", 64'(d), 64'd0);
    end
    chk("R11 irq at reset", 64'(irq), 64'd0);
    chk("R7 ready with ring off", 64'(ev_ready), 64'd0);

    reg_wr(3'd0, 32'h00AB_CD12);
    reg_wr(3'd1, 32'h0000_003C);
    reg_wr(3'd6, 32'h0000_F004);
    reg_wr(3'd7, 32'h0000_0012);
    reg_wr(3'd5, 32'h0001_002A);
    size = 5; ring_en = 1; irq_en = 1; ovf_en = 1;
    set_ctrl();
    chk("R7 ready once enabled", 64'(ev_ready), 64'd1);

    // random phase
    for (int k = 0; k < 40; k++) begin
      if (k == 20) begin
        ring_en = 0; set_ctrl();
        reg_wr(3'd3, 32'd0); reg_wr(3'd4, 32'd0);
        exp_wptr = 0; exp_rptr = 0;
        reg_rd(3'd3, d);
        chk("R12 wptr cleared by write", 64'(d), 64'(f_img(0, exp_ovf)));
        size = 6; ring_en = 1; set_ctrl();
      end
      if (k % 10 == 5) begin wb_en = ~wb_en; set_ctrl(); end
      case ($urandom % 3)
        1: set_rptr_reg(exp_wptr);
        2: set_rptr_db(exp_wptr);
        default: ;
      endcase
      send_entry(rnd_entry());
    end

    // R4 directed overflow, 8-entry ring
    wb_en = 0; clr = 1; set_ctrl(); clr = 0; set_ctrl();
    set_rptr_reg(exp_wptr);
    for (int i = 0; i < 7; i++) send_entry(rnd_entry());
    chk("R4 no flag before full", 64'(exp_ovf), 64'd0);
    send_entry(rnd_entry());
    reg_rd(3'd3, d);
    chk("R4 flag on wrap onto rptr", 64'(d[31]), 64'd1);
    chk("R8 irq low when pointers meet", 64'(irq), 64'd0);

    // R5 clear holds flag low and masks detection
    clr = 1; set_ctrl();
    reg_rd(3'd3, d);
    chk("R5 flag cleared", 64'(d[31]), 64'd0);
    set_rptr_reg((exp_wptr + 32) & mask);
    send_entry(rnd_entry());
    clr = 0; set_ctrl();
    reg_rd(3'd3, d);
    chk("R5 no detection while clear", 64'(d[31]), 64'd0);

    // R10 doorbell filtering and priority
    set_rptr_reg(exp_wptr);
    @(negedge clk); db_v_a = 1'b1; db_off_a = 10'h15; db_d_a = 32'h20;
    @(negedge clk); db_v_a = 1'b0;
    reg_rd(3'd4, d);
    chk("R10 offset mismatch ignored", 64'(d), 64'(exp_rptr));
    reg_wr(3'd5, 32'h0000_002A);
    @(negedge clk); db_v_a = 1'b1; db_off_a = 10'h2A; db_d_a = 32'h40;
    @(negedge clk); db_v_a = 1'b0;
    reg_rd(3'd4, d);
    chk("R10 disabled doorbell ignored", 64'(d), 64'(exp_rptr));
    reg_wr(3'd5, 32'h0001_002A);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 32'h60;
    db_v_a = 1'b1; db_off_a = 10'h2A; db_d_a = 32'h20;
    @(negedge clk); reg_we = 1'b0; db_v_a = 1'b0; exp_rptr = 32'h60;
    reg_rd(3'd4, d);
    chk("R10 register write wins", 64'(d), 64'h60);

    // commit and doorbell on the same edge
    set_rptr_reg((exp_wptr + 32) & mask);
    hook_val = (exp_wptr + 96) & mask; hook_armed = 1;
    send_entry(rnd_entry());
    reg_rd(3'd3, d);
    chk("R4 flag uses old rptr", 64'(d[31]), 64'd1);
    reg_rd(3'd4, d);
    chk("R10 same-edge doorbell value", 64'(d), 64'(hook_val));

    // R6 writeback carrying the flag
    wb_en = 1; set_ctrl();
    send_entry(rnd_entry());

    // R8 interrupt gating
    irq_en = 0; set_ctrl();
    chk("R8 irq gated off", 64'(irq), 64'd0);
    irq_en = 1; set_ctrl();
    chk("R8 irq restored", 64'(irq), 64'(f_irq()));

    // R7 ring disabled blocks entries
    ring_en = 0; set_ctrl();
    log_a.delete();
    @(negedge clk); ev_valid = 1'b1;
    repeat (6) @(negedge clk);
    chk("R7 ready low when disabled", 64'(ev_ready), 64'd0);
    chk("R7 no writes when disabled", 64'(log_a.size()), 64'd0);
    ev_valid = 1'b0;

    // R12 wptr write keeps flag
    reg_wr(3'd3, 32'h0000_0047);
    reg_rd(3'd3, d);
    chk("R12 wptr write aligned", 64'(d), 64'(f_img(32'h40 & mask, exp_ovf)));

    finish_run();
  end
endmodule